// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the per-source state for a bank of interrupt sources and turns source activity into delivery offers for a presentation stage. Each source has a fixed kind, message or level, chosen by a parameter mask. Each source also holds a target server index, a current priority, a saved priority, and four state flags: line asserted, offer sent, offer rejected, and fired-while-masked. A priority of 0xFF means the source is masked. Sources are addressed by global numbers running from `BASE` to `BASE+NSRC-1`.

The presenter drives three control inputs back into the block. A reject names a source whose offer it turned away. An end-of-interrupt names a source it has finished with. A resend pulse asks the block to offer again everything that is still owed. Software-side configuration arrives as one command per cycle: set, disable or enable. Each command gets a one-cycle response with an error bit one cycle later.

Offers leave through a valid/ready stream that carries the global number, the priority and the server. An offer is loaded from the lowest-numbered source that owes one, and it is held unchanged until `offer_ready` is seen. The next offer can be loaded on the same edge as the handshake, so the stream can move one offer per cycle when ready stays high. While `offer_ready` is low, queued offers simply wait; nothing is dropped.

Top module: `isc_src_ctrl`

## Requirements
- R1: After reset no offer and no response is presented, every server field is 0, every flag is clear, and every priority and saved priority is 0xFF, so a message pulse right after reset produces no offer.
- R2: A one-cycle `src_in` pulse on an unmasked message source makes `offer_valid` rise two clock edges after the pulse edge. The offer carries `offer_num` = BASE + source index, plus the source's priority and server.
- R3: A message pulse while the source is masked produces no offer and records fired-while-masked. A later accepted command that leaves the priority below 0xFF clears that record and produces exactly one offer.
- R4: On a level source, a rising `src_in` while the source is unmasked and has no offer outstanding produces one offer and sets the sent flag. While the sent flag is set, no further offer follows.
- R5: A reject sets the rejected flag and clears the sent flag. An end-of-interrupt clears the sent flag, and only for level sources. Neither one produces an offer by itself. Numbers outside the range are ignored.
- R6: A resend re-offers each message source whose rejected flag is set, once, if it is unmasked, and clears that flag. It re-applies the level offer rule (unmasked, line high, not sent) to every level source.
- R7: When several offers are owed at once, they leave in ascending source number, one per handshake.
- R8: Command encodings are `cfg_op` 0 = set, 1 = disable, 2 = enable; value 3 is refused. The response (`cfg_rsp_valid`) comes one cycle after `cfg_valid`. `cfg_rsp_err` is 1 for an out-of-range number, and for a set whose server is not below NSERV or whose 9-bit priority is above 0xFF. A refused command changes no state.
- R9: Disable copies the current priority into the saved priority and sets the priority to 0xFF. Enable copies the saved priority back into the priority. Either command then applies the same follow-up rules as a set.
- R10: While `offer_valid` is high and `offer_ready` is low, `offer_valid`, `offer_num`, `offer_prio` and `offer_server` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NSRC | Per source: level line, or one-cycle message pulse |
| cfg_valid | input | 1 | Command strobe |
| cfg_op | input | 2 | Command: 0 set, 1 disable, 2 enable |
| cfg_num | input | NUM_W | Global source number of the command |
| cfg_server | input | SRV_W | Server index for set |
| cfg_prio | input | 9 | Priority for set (values above 0xFF are refused) |
| cfg_rsp_valid | output | 1 | Response strobe, one cycle after the command |
| cfg_rsp_err | output | 1 | Command refused |
| rej_valid | input | 1 | Presenter rejects an offer |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend | input | 1 | Re-offer owed sources |
| offer_valid | output | 1 | Offer present |
| offer_ready | input | 1 | Presenter takes the offer |
| offer_num | output | NUM_W | Global source number offered |
| offer_prio | output | 8 | Priority offered |
| offer_server | output | SRV_W | Target server offered |

## Verification
The embedded properties assume that a message source's `src_in` is high for one cycle per event and that at most one command arrives per cycle. They make no assumption about when `offer_ready` is asserted, so the hold property covers arbitrary stalls. The directed stimulus keeps to these rules. It drives every input at the falling edge, pulses message inputs for exactly one cycle, and deliberately holds `offer_ready` low while several offers are owed, so that both the ordering and the hold behaviour are exercised.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef enum logic [1:0] {
    OP_SET     = 2'd0,
    OP_DISABLE = 2'd1,
    OP_ENABLE  = 2'd2
  } cfg_op_e;

  localparam logic [7:0] PRIO_OFF = 8'hFF;
endpackage

// File: rtl/isc_num_decode.sv
module isc_num_decode #(
  parameter int NSRC  = 8,
  parameter int NUM_W = 8,
  parameter int BASE  = 32
) (
  input  logic             en,
  input  logic [NUM_W-1:0] num,
  output logic [NSRC-1:0]  hit
);
  localparam logic [NUM_W-1:0] FIRST = NUM_W'(BASE);
  localparam logic [NUM_W-1:0] LIMIT = NUM_W'(BASE + NSRC);

  logic             in_win;
  logic [NUM_W-1:0] rel;

  assign in_win = (num >= FIRST) && (num < LIMIT);
  assign rel    = num - FIRST;

  for (genvar g = 0; g < NSRC; g++) begin : g_hit
    assign hit[g] = en && in_win && (rel == NUM_W'(g));
  end
endmodule

// File: rtl/isc_cfg_port.sv
module isc_cfg_port
  import isc_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int NUM_W = 8,
  parameter int SRV_W = 4,
  parameter int NSERV = 4,
  parameter int BASE  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic [1:0]       cfg_op,
  input  logic [NUM_W-1:0] cfg_num,
  input  logic [SRV_W-1:0] cfg_server,
  input  logic [8:0]       cfg_prio,
  output logic [NSRC-1:0]  cfg_hit,
  output logic             cfg_rsp_valid,
  output logic             cfg_rsp_err
);
  logic [NSRC-1:0] num_hit;
  logic            num_ok;
  logic            args_ok;

  isc_num_decode #(.NSRC(NSRC), .NUM_W(NUM_W), .BASE(BASE)) u_dec (
    .en (cfg_valid),
    .num(cfg_num),
    .hit(num_hit)
  );

  assign num_ok = |num_hit;

  always_comb begin
    args_ok = 1'b0;
    if (num_ok) begin
      if (cfg_op == OP_DISABLE || cfg_op == OP_ENABLE) begin
        args_ok = 1'b1;
      end else if (cfg_op == OP_SET) begin
        args_ok = ({1'b0, cfg_server} < (SRV_W+1)'(NSERV)) && !cfg_prio[8];
      end
    end
  end

  assign cfg_hit = args_ok ? num_hit : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rsp_valid <= 1'b0;
      cfg_rsp_err   <= 1'b0;
    end else begin
      cfg_rsp_valid <= cfg_valid;
      cfg_rsp_err   <= cfg_valid && !args_ok;
    end
  end

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rsp_valid |-> $past(cfg_valid)); // R8
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_hit)); // R8
endmodule

// File: rtl/isc_src_cell.sv
module isc_src_cell
  import isc_pkg::*;
#(
  parameter int SRV_W = 4,
  parameter bit LEVEL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line,
  input  logic             cfg_hit,
  input  logic [1:0]       cfg_op,
  input  logic [SRV_W-1:0] cfg_server,
  input  logic [7:0]       cfg_prio,
  input  logic             rej_hit,
  input  logic             eoi_hit,
  input  logic             resend,
  input  logic             load_hit,
  output logic             queued,
  output logic [7:0]       prio,
  output logic [SRV_W-1:0] server
);
  logic             asserted_q, sent_q, rej_q, mpend_q, queued_q;
  logic [7:0]       prio_q, saved_q;
  logic [SRV_W-1:0] server_q;

  logic             asserted_n, sent_n, rej_n, mpend_n, queued_n;
  logic [7:0]       prio_n, saved_n;
  logic [SRV_W-1:0] server_n;
  logic             eval;

  always_comb begin
    asserted_n = asserted_q;
    sent_n     = sent_q;
    rej_n      = rej_q;
    mpend_n    = mpend_q;
    queued_n   = queued_q && !load_hit;
    prio_n     = prio_q;
    saved_n    = saved_q;
    server_n   = server_q;
    eval       = 1'b0;

    if (rej_hit) begin
      rej_n  = 1'b1;
      sent_n = 1'b0;
    end
    if (eoi_hit && LEVEL) sent_n = 1'b0;

    if (LEVEL) begin
      asserted_n = line;
      if (line && !asserted_q) eval = 1'b1;
    end else if (line) begin
      if (prio_q == PRIO_OFF) mpend_n = 1'b1;
      else                    queued_n = 1'b1;
    end

    if (cfg_hit) begin
      case (cfg_op)
        OP_SET: begin
          server_n = cfg_server;
          prio_n   = cfg_prio;
          saved_n  = cfg_prio;
        end
        OP_DISABLE: begin
          saved_n = prio_q;
          prio_n  = PRIO_OFF;
        end
        OP_ENABLE: prio_n = saved_q;
        default: ;
      endcase
      if (LEVEL) begin
        eval = 1'b1;
      end else if (mpend_n && prio_n != PRIO_OFF) begin
        mpend_n  = 1'b0;
        queued_n = 1'b1;
      end
    end

    if (resend) begin
      if (LEVEL) begin
        eval = 1'b1;
      end else if (rej_n) begin
        rej_n = 1'b0;
        if (prio_n != PRIO_OFF) queued_n = 1'b1;
      end
    end

    if (LEVEL && eval && prio_n != PRIO_OFF && asserted_n && !sent_n) begin
      sent_n   = 1'b1;
      queued_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asserted_q <= 1'b0;
      sent_q     <= 1'b0;
      rej_q      <= 1'b0;
      mpend_q    <= 1'b0;
      queued_q   <= 1'b0;
      prio_q     <= PRIO_OFF;
      saved_q    <= PRIO_OFF;
      server_q   <= '0;
    end else begin
      asserted_q <= asserted_n;
      sent_q     <= sent_n;
      rej_q      <= rej_n;
      mpend_q    <= mpend_n;
      queued_q   <= queued_n;
      prio_q     <= prio_n;
      saved_q    <= saved_n;
      server_q   <= server_n;
    end
  end

  assign queued = queued_q;
  assign prio   = prio_q;
  assign server = server_q;

  AST_SENT_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sent_q) |-> (LEVEL && asserted_q)); // R4
  AST_DISABLE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hit && cfg_op == OP_DISABLE) |=> (prio_q == PRIO_OFF)); // R9
  AST_ENABLE_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hit && cfg_op == OP_ENABLE) |=> (prio_q == $past(saved_q))); // R9
endmodule

// File: rtl/isc_offer_arb.sv
module isc_offer_arb
  import isc_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int NUM_W = 8,
  parameter int SRV_W = 4,
  parameter int BASE  = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSRC-1:0]             cand,
  input  logic [NSRC-1:0][7:0]        prio_vec,
  input  logic [NSRC-1:0][SRV_W-1:0]  server_vec,
  input  logic                        offer_ready,
  output logic [NSRC-1:0]             load_hit,
  output logic                        offer_valid,
  output logic [NUM_W-1:0]            offer_num,
  output logic [7:0]                  offer_prio,
  output logic [SRV_W-1:0]            offer_server
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [IDX_W-1:0] sel;
  logic             found;
  logic             load;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && !found) begin
        found = 1'b1;
        sel   = IDX_W'(i);
      end
    end
  end

  assign load = found && (!offer_valid || offer_ready);

  for (genvar g = 0; g < NSRC; g++) begin : g_load
    assign load_hit[g] = load && (sel == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offer_valid  <= 1'b0;
      offer_num    <= '0;
      offer_prio   <= PRIO_OFF;
      offer_server <= '0;
    end else if (load) begin
      offer_valid  <= 1'b1;
      offer_num    <= NUM_W'(BASE) + NUM_W'(sel);
      offer_prio   <= prio_vec[sel];
      offer_server <= server_vec[sel];
    end else if (offer_ready) begin
      offer_valid  <= 1'b0;
    end
  end

  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && !offer_ready) |=> (offer_valid && $stable(offer_num)
      && $stable(offer_prio) && $stable(offer_server))); // R10
  AST_OFFER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> (offer_prio != PRIO_OFF)); // R2
endmodule

// File: rtl/isc_src_ctrl.sv
module isc_src_ctrl
  import isc_pkg::*;
#(
  parameter int              NSRC       = 8,
  parameter int              NUM_W      = 8,
  parameter int              SRV_W      = 4,
  parameter int              NSERV      = 4,
  parameter int              BASE       = 32,
  parameter logic [NSRC-1:0] LEVEL_MASK = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_in,
  input  logic             cfg_valid,
  input  logic [1:0]       cfg_op,
  input  logic [NUM_W-1:0] cfg_num,
  input  logic [SRV_W-1:0] cfg_server,
  input  logic [8:0]       cfg_prio,
  output logic             cfg_rsp_valid,
  output logic             cfg_rsp_err,
  input  logic             rej_valid,
  input  logic [NUM_W-1:0] rej_num,
  input  logic             eoi_valid,
  input  logic [NUM_W-1:0] eoi_num,
  input  logic             resend,
  output logic             offer_valid,
  input  logic             offer_ready,
  output logic [NUM_W-1:0] offer_num,
  output logic [7:0]       offer_prio,
  output logic [SRV_W-1:0] offer_server
);
  logic [NSRC-1:0]            cfg_hit, rej_hit, eoi_hit, load_hit, queued, cand;
  logic [NSRC-1:0][7:0]       prio_vec;
  logic [NSRC-1:0][SRV_W-1:0] server_vec;

  isc_cfg_port #(.NSRC(NSRC), .NUM_W(NUM_W), .SRV_W(SRV_W), .NSERV(NSERV),
                 .BASE(BASE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_op(cfg_op),
    .cfg_num(cfg_num), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
    .cfg_hit(cfg_hit), .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_err(cfg_rsp_err)
  );

  isc_num_decode #(.NSRC(NSRC), .NUM_W(NUM_W), .BASE(BASE)) u_rej_dec (
    .en(rej_valid), .num(rej_num), .hit(rej_hit)
  );

  isc_num_decode #(.NSRC(NSRC), .NUM_W(NUM_W), .BASE(BASE)) u_eoi_dec (
    .en(eoi_valid), .num(eoi_num), .hit(eoi_hit)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    isc_src_cell #(.SRV_W(SRV_W), .LEVEL(LEVEL_MASK[g])) u_cell (
      .clk(clk), .rst_n(rst_n), .line(src_in[g]),
      .cfg_hit(cfg_hit[g]), .cfg_op(cfg_op), .cfg_server(cfg_server),
      .cfg_prio(cfg_prio[7:0]), .rej_hit(rej_hit[g]), .eoi_hit(eoi_hit[g]),
      .resend(resend), .load_hit(load_hit[g]), .queued(queued[g]),
      .prio(prio_vec[g]), .server(server_vec[g])
    );
    assign cand[g] = queued[g] && (prio_vec[g] != PRIO_OFF);
  end

  isc_offer_arb #(.NSRC(NSRC), .NUM_W(NUM_W), .SRV_W(SRV_W), .BASE(BASE)) u_arb (
    .clk(clk), .rst_n(rst_n), .cand(cand), .prio_vec(prio_vec),
    .server_vec(server_vec), .offer_ready(offer_ready), .load_hit(load_hit),
    .offer_valid(offer_valid), .offer_num(offer_num), .offer_prio(offer_prio),
    .offer_server(offer_server)
  );
endmodule

// File: tb/isc_src_ctrl_tb_top.sv
`timescale 1ns/1ps
module isc_src_ctrl_tb_top;
  localparam int NSRC = 8, NUM_W = 8, SRV_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NSRC-1:0]  src_in = '0;
  logic             cfg_valid = 1'b0;
  logic [1:0]       cfg_op = '0;
  logic [NUM_W-1:0] cfg_num = '0;
  logic [SRV_W-1:0] cfg_server = '0;
  logic [8:0]       cfg_prio = '0;
  logic             cfg_rsp_valid, cfg_rsp_err;
  logic             rej_valid = 1'b0, eoi_valid = 1'b0, resend = 1'b0;
  logic [NUM_W-1:0] rej_num = '0, eoi_num = '0;
  logic             offer_valid;
  logic             offer_ready = 1'b0;
  logic [NUM_W-1:0] offer_num;
  logic [7:0]       offer_prio;
  logic [SRV_W-1:0] offer_server;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  isc_src_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .cfg_valid(cfg_valid),
    .cfg_op(cfg_op), .cfg_num(cfg_num), .cfg_server(cfg_server),
    .cfg_prio(cfg_prio), .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_err(cfg_rsp_err),
    .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid),
    .eoi_num(eoi_num), .resend(resend), .offer_valid(offer_valid),
    .offer_ready(offer_ready), .offer_num(offer_num), .offer_prio(offer_prio),
    .offer_server(offer_server)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fire(input int i);
    @(negedge clk) src_in[i] = 1'b1;
    @(negedge clk) src_in[i] = 1'b0;
  endtask

  task automatic cmd(input int op, input int num, input int srv, input int pr,
                     input bit exp_err, input string req);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_op = 2'(op); cfg_num = NUM_W'(num);
    cfg_server = SRV_W'(srv); cfg_prio = 9'(pr);
    @(negedge clk);
    cfg_valid = 1'b0;
    check(cfg_rsp_valid === 1'b1, req, "response strobe", int'(cfg_rsp_valid), 1);
    check(cfg_rsp_err === exp_err, req, "response error", int'(cfg_rsp_err), int'(exp_err));
  endtask

  task automatic reject(input int num);
    @(negedge clk) begin rej_valid = 1'b1; rej_num = NUM_W'(num); end
    @(negedge clk) rej_valid = 1'b0;
  endtask

  task automatic eoi(input int num);
    @(negedge clk) begin eoi_valid = 1'b1; eoi_num = NUM_W'(num); end
    @(negedge clk) eoi_valid = 1'b0;
  endtask

  task automatic do_resend();
    @(negedge clk) resend = 1'b1;
    @(negedge clk) resend = 1'b0;
  endtask

  task automatic expect_offer(input int num, input int pr, input int srv,
                              input string req);
    int waited = 0;
    while (!offer_valid && waited < 8) begin
      @(negedge clk);
      waited++;
    end
    check(offer_valid === 1'b1, req, "offer present", int'(offer_valid), 1);
    check(offer_num == NUM_W'(num), req, "offer number", int'(offer_num), num);
    check(offer_prio == 8'(pr), req, "offer priority", int'(offer_prio), pr);
    check(offer_server == SRV_W'(srv), req, "offer server", int'(offer_server), srv);
    offer_ready = 1'b1;
    @(negedge clk) offer_ready = 1'b0;
  endtask

  task automatic expect_quiet(input int cycles, input string req);
    bit seen = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (offer_valid) seen = 1'b1;
    end
    check(!seen, req, "no offer expected", int'(seen), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(offer_valid === 1'b0, "R1", "offer during reset", int'(offer_valid), 0);
    check(cfg_rsp_valid === 1'b0, "R1", "response during reset", int'(cfg_rsp_valid), 0);
    rst_n = 1'b1;
    fire(0);
    expect_quiet(4, "R1");
  endtask

  task automatic t_masked_message();
    cmd(0, 32, 2, 5, 1'b0, "R8");
    expect_offer(32, 5, 2, "R3");
    expect_quiet(3, "R3");
  endtask

  task automatic t_message();
    cmd(0, 33, 1, 3, 1'b0, "R8");
    expect_quiet(3, "R2");
    fire(1);
    expect_offer(33, 3, 1, "R2");
  endtask

  task automatic t_cmd_errors();
    cmd(0, 31, 0, 1, 1'b1, "R8");
    cmd(0, 40, 0, 1, 1'b1, "R8");
    cmd(0, 35, 4, 1, 1'b1, "R8");
    cmd(0, 35, 0, 256, 1'b1, "R8");
    cmd(3, 35, 0, 1, 1'b1, "R8");
    cmd(1, 40, 0, 0, 1'b1, "R8");
    fire(3);
    expect_quiet(4, "R8");
  endtask

  task automatic t_level();
    cmd(0, 36, 0, 7, 1'b0, "R4");
    expect_quiet(3, "R4");
    @(negedge clk) src_in[4] = 1'b1;
    expect_offer(36, 7, 0, "R4");
    expect_quiet(4, "R4");
    eoi(36);
    expect_quiet(3, "R5");
    do_resend();
    expect_offer(36, 7, 0, "R6");
    reject(36);
    expect_quiet(3, "R5");
    do_resend();
    expect_offer(36, 7, 0, "R6");
    eoi(36);
    @(negedge clk) src_in[4] = 1'b0;
    do_resend();
    expect_quiet(4, "R6");
  endtask

  task automatic t_message_reject();
    reject(33);
    expect_quiet(3, "R5");
    reject(50);
    do_resend();
    expect_offer(33, 3, 1, "R6");
    do_resend();
    expect_quiet(3, "R6");
  endtask

  task automatic t_disable_enable();
    cmd(1, 33, 0, 0, 1'b0, "R9");
    fire(1);
    expect_quiet(3, "R9");
    cmd(2, 33, 0, 0, 1'b0, "R9");
    expect_offer(33, 3, 1, "R9");
  endtask

  task automatic t_order();
    int held_num, held_prio;
    cmd(0, 34, 3, 4, 1'b0, "R7");
    reject(34);
    reject(33);
    do_resend();
    repeat (3) @(negedge clk);
    check(offer_valid === 1'b1, "R7", "first offer present", int'(offer_valid), 1);
    check(offer_num == 8'd33, "R7", "lowest first", int'(offer_num), 33);
    held_num = int'(offer_num);
    held_prio = int'(offer_prio);
    repeat (2) @(negedge clk);
    check(offer_valid === 1'b1 && int'(offer_num) == held_num, "R10",
          "number held under stall", int'(offer_num), held_num);
    check(int'(offer_prio) == held_prio, "R10", "priority held under stall",
          int'(offer_prio), held_prio);
    expect_offer(33, 3, 1, "R7");
    expect_offer(34, 4, 3, "R7");
    expect_quiet(3, "R7");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    t_reset();
    t_masked_message();
    t_message();
    t_cmd_errors();
    t_level();
    t_message_reject();
    t_disable_enable();
    t_order();
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end
endmodule